// File: doc/BRIEF.md
# Paired-Clock Multichannel PWM Controller

This block produces up to sixteen pulse-width-modulated outputs from a small register file. Channels are grouped in twos: each pair shares one clock-setup register, which picks the source (a high-speed oscillator or the bus clock) and a power-of-two divider. Each channel then has its own 8-bit prescaler, which divides by k+1. The resulting scaled tick drives a 16-bit counter that runs from zero up to a programmed cycle limit. The output holds the programmed active level while the counter is below the active count, and the opposite level for the rest of the period.

The two clock sources arrive as single-cycle enable strobes in the block's own clock domain. Software programs the controller through a simple write/read port with byte addresses. Each channel also drives an output-enable, so an external pad can float while the channel is off. A bypass bit per channel routes the selected source strobe straight to the output. A gate bit per channel freezes the channel's counter without disturbing its settings. New timing values act at once: the running period is never completed first.

Top module: `pwm_pair_ctrl`

## Requirements
- R1: After reset every register reads zero, every `pwm_oe` bit is low and every channel counter is zero.
- R2: Pair register p sits at byte address 0x20+4p and holds the source select in bits [8:7] and the divider exponent in bits [3:0]. Channel n's control register sits at 0x100+0x20n and holds the active level in bit 8 (1 = active high) and the prescaler k in bits [7:0]. Its period register at 0x104+0x20n holds the cycle limit E in [31:16] and the active count A in [15:0]. The gate register at 0x40 holds the gate bit for channel n at bit n and its bypass bit at bit 16+n. The enable register is at 0x80, bit n. Every implemented field reads back as written, and every other bit of these registers reads zero.
- R3: An address that maps to no register reads zero, and a write to it changes no register.
- R4: `pwm_oe[n]` equals enable bit n. While that bit is clear, the channel's counter and prescaler are held at zero.
- R5: Source select 0 uses `osc_tick`, 1 uses `bus_tick`, and 2 or 3 supply no ticks, so the counter stays still.
- R6: The pair divider passes one of every 2^d source ticks; a value of d above 8 acts as 8.
- R7: The channel prescaler passes one of every k+1 divided ticks.
- R8: On each scaled tick the counter steps from 0 up to E and then back to 0, giving a period of E+1 scaled ticks. The output is at the active level while the counter is below A and at the opposite level otherwise, so A > E gives a constant active level.
- R9: Channels 2p and 2p+1 both take their source and divider from pair register p and are independent of every other pair.
- R10: New period, duty and divider values take effect immediately: if the counter is at or above a newly written E, it returns to 0 on the next scaled tick.
- R11: While a channel is enabled and its gate bit is clear, its counter and output hold still.
- R12: While bypass bit n is set, `pwm_out[n]` follows the selected source strobe of its pair, undivided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| osc_tick | input | 1 | Oscillator source strobe, one cycle per source edge |
| bus_tick | input | 1 | Bus-clock source strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pwm_out | output | NUM_CH | PWM levels |
| pwm_oe | output | NUM_CH | Output enables; low lets the pad float |

## Verification
Duty and period are measured by counting high cycles over a whole number of periods. This catches a design that is off by one in the wrap point or the prescaler, since that design gives the wrong count. Sources are exercised with a strobe every cycle and one every third cycle; a mix-up of the source selects shows as a threefold error. The reserved source code is also covered, and a design that ticked anyway would toggle. A divider exponent above 8 is checked for clamping; a design that did not clamp would show a much longer or wrapped period. The bench lowers E beneath a running count: a design that finished the old period would stay high for hundreds of cycles. Separate tests check that gating freezes the output, that two pairs with different dividers do not interact, and that a write to an address gap leaves the neighbouring registers unchanged.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

  localparam int CNT_W   = 16;
  localparam int PRE_W   = 8;
  localparam int DIV_W   = 4;
  localparam int DIV_MAX = 8;

  localparam logic [31:0] GATE_ADDR = 32'h40;
  localparam logic [31:0] EN_ADDR   = 32'h80;

  typedef struct packed {
    logic [1:0]       src;
    logic [DIV_W-1:0] div;
  } pair_cfg_t;

  typedef struct packed {
    logic             pol;
    logic [PRE_W-1:0] pre;
  } ctl_t;

  typedef struct packed {
    logic [CNT_W-1:0] entire;
    logic [CNT_W-1:0] active;
  } per_t;

  function automatic logic [31:0] pair_addr(input int p);
    return 32'(32'h20 + 4 * p);
  endfunction

  function automatic logic [31:0] ctl_addr(input int c);
    return 32'(32'h100 + 32'h20 * c);
  endfunction

  function automatic logic [31:0] per_addr(input int c);
    return 32'(32'h104 + 32'h20 * c);
  endfunction

  // mask of low divider bits that must all be set for a divided tick
  function automatic logic [PRE_W-1:0] div_mask(input logic [DIV_W-1:0] d);
    logic [DIV_W-1:0] eff;
    logic [PRE_W:0]   m;
    eff = (d > DIV_W'(DIV_MAX)) ? DIV_W'(DIV_MAX) : d;
    m   = ((PRE_W+1)'(1) << eff) - (PRE_W+1)'(1);
    return m[PRE_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] e);
    return (c >= e) ? '0 : c + CNT_W'(1);
  endfunction

  function automatic logic out_level(input logic [CNT_W-1:0] c,
                                     input logic [CNT_W-1:0] a,
                                     input logic pol);
    return (c < a) ? pol : ~pol;
  endfunction

endpackage

// File: rtl/pwmc_regs.sv
module pwmc_regs
  import pwmc_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12,
  localparam int NP    = (NUM_CH + 1) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output pair_cfg_t         pair_o [NP],
  output logic [NUM_CH-1:0] gate_o,
  output logic [NUM_CH-1:0] bypass_o,
  output logic [NUM_CH-1:0] en_o,
  output ctl_t              ctl_o [NUM_CH],
  output per_t              per_o [NUM_CH]
);

  logic [31:0] a32;
  assign a32 = 32'(addr_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_o   <= '0;
      bypass_o <= '0;
      en_o     <= '0;
      for (int p = 0; p < NP; p++) pair_o[p] <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        ctl_o[c] <= '0;
        per_o[c] <= '0;
      end
    end else if (wr_i) begin
      if (a32 == GATE_ADDR) begin
        gate_o   <= wdata_i[NUM_CH-1:0];
        bypass_o <= wdata_i[16 +: NUM_CH];
      end
      if (a32 == EN_ADDR) en_o <= wdata_i[NUM_CH-1:0];
      for (int p = 0; p < NP; p++)
        if (a32 == pair_addr(p)) pair_o[p] <= '{src: wdata_i[8:7], div: wdata_i[3:0]};
      for (int c = 0; c < NUM_CH; c++) begin
        if (a32 == ctl_addr(c)) ctl_o[c] <= '{pol: wdata_i[8], pre: wdata_i[7:0]};
        if (a32 == per_addr(c)) per_o[c] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (a32 == GATE_ADDR) begin
      rdata_o[NUM_CH-1:0]   = gate_o;
      rdata_o[16 +: NUM_CH] = bypass_o;
    end
    if (a32 == EN_ADDR) rdata_o[NUM_CH-1:0] = en_o;
    for (int p = 0; p < NP; p++)
      if (a32 == pair_addr(p)) begin
        rdata_o[8:7] = pair_o[p].src;
        rdata_o[3:0] = pair_o[p].div;
      end
    for (int c = 0; c < NUM_CH; c++) begin
      if (a32 == ctl_addr(c)) begin
        rdata_o[8]   = ctl_o[c].pol;
        rdata_o[7:0] = ctl_o[c].pre;
      end
      if (a32 == per_addr(c)) rdata_o = per_o[c];
    end
  end

  // R2: a write to the enable register lands on the next cycle
  p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && a32 == EN_ADDR) |=> (en_o == $past(wdata_i[NUM_CH-1:0])));

endmodule

// File: rtl/pwmc_pair_div.sv
module pwmc_pair_div
  import pwmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      osc_tick_i,
  input  logic      bus_tick_i,
  input  pair_cfg_t cfg_i,
  output logic      src_tick_o,
  output logic      div_tick_o
);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    unique case (cfg_i.src)
      2'd0:    src_tick_o = osc_tick_i;
      2'd1:    src_tick_o = bus_tick_i;
      default: src_tick_o = 1'b0;
    endcase
  end

  assign mask       = div_mask(cfg_i.div);
  assign div_tick_o = src_tick_o && ((cnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (src_tick_o) cnt_q <= cnt_q + PRE_W'(1);
  end

  // R6: a divided tick is always one of the source ticks
  p_div_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick_o |-> src_tick_o);

  // R6: exponent zero passes every source tick
  p_div_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.div == '0) |-> (div_tick_o == src_tick_o));

endmodule

// File: rtl/pwmc_chan.sv
module pwmc_chan
  import pwmc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic gate_i,
  input  logic bypass_i,
  input  ctl_t ctl_i,
  input  per_t per_i,
  input  logic src_tick_i,
  input  logic div_tick_i,
  output logic pwm_o,
  output logic oe_o
);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pre_done;
  logic             scaled_tick;

  assign pre_done    = (pre_q >= ctl_i.pre);
  assign scaled_tick = en_i && gate_i && div_tick_i && pre_done;

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (gate_i && div_tick_i) begin
      pre_q <= pre_done ? '0 : pre_q + PRE_W'(1);
      if (pre_done) cnt_q <= next_count(cnt_q, per_i.entire);
    end
  end

  assign pwm_o = bypass_i ? src_tick_i : out_level(cnt_q, per_i.active, ctl_i.pol);
  assign oe_o  = en_i;

  // R4: a disabled channel sits at zero
  p_idle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0 && pre_q == '0));

  // R11: gated channel holds its count
  p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !gate_i) |=> $stable(cnt_q));

  // R10: at or beyond the limit the next tick returns to zero
  p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scaled_tick && cnt_q >= per_i.entire) |=> (cnt_q == '0));

  // R8: below the limit each tick advances by one
  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scaled_tick && cnt_q < per_i.entire) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/pwm_pair_ctrl.sv
module pwm_pair_ctrl
  import pwmc_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              bus_tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] pwm_oe
);

  localparam int NP = (NUM_CH + 1) / 2;

  pair_cfg_t         pair_cfg [NP];
  ctl_t              ctl      [NUM_CH];
  per_t              per      [NUM_CH];
  logic [NUM_CH-1:0] gate, bypass, en;
  logic [NP-1:0]     src_tick, div_tick;

  pwmc_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (reg_wr),
    .addr_i   (reg_addr),
    .wdata_i  (reg_wdata),
    .rdata_o  (reg_rdata),
    .pair_o   (pair_cfg),
    .gate_o   (gate),
    .bypass_o (bypass),
    .en_o     (en),
    .ctl_o    (ctl),
    .per_o    (per)
  );

  for (genvar p = 0; p < NP; p++) begin : g_pair
    pwmc_pair_div u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .osc_tick_i (osc_tick),
      .bus_tick_i (bus_tick),
      .cfg_i      (pair_cfg[p]),
      .src_tick_o (src_tick[p]),
      .div_tick_o (div_tick[p])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    localparam int PAIR = c / 2;
    pwmc_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en[c]),
      .gate_i     (gate[c]),
      .bypass_i   (bypass[c]),
      .ctl_i      (ctl[c]),
      .per_i      (per[c]),
      .src_tick_i (src_tick[PAIR]),
      .div_tick_i (div_tick[PAIR]),
      .pwm_o      (pwm_out[c]),
      .oe_o       (pwm_oe[c])
    );
  end

endmodule

// File: tb/test_pwm_pair_ctrl.sv
module test_pwm_pair_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_tick = 1'b1;
  logic        bus_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] pwm_out, pwm_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int phase  = 0;

  pwm_pair_ctrl i_pwm_pair_ctrl (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_tick(bus_tick),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  always #5 clk = ~clk;

  // bus strobe: one cycle in three
  always @(posedge clk) begin
    #2;
    phase    = (phase == 2) ? 0 : phase + 1;
    bus_tick = (phase == 0);
  end

  typedef struct packed {
    int src; int dv; int pre; int ent; int act; int pol; int win; int exp;
  } row_t;

  // src, div, prescaler, E, A, level, window, expected high cycles
  localparam row_t ROWS [9] = '{
    '{0, 0,  0, 9,    3, 1,   20,   6},
    '{0, 1,  0, 4,    2, 1,   20,   8},
    '{0, 0,  2, 3,    1, 0,   24,  18},
    '{0, 2,  1, 2,    0, 1,   48,   0},
    '{0, 0,  0, 5,    9, 1,   12,  12},
    '{0, 12, 0, 1,    1, 1, 1024, 512},
    '{1, 0,  0, 3,    2, 1,   24,  12},
    '{2, 0,  0, 3,    1, 0,   24,   0},
    '{1, 1,  1, 1,    1, 0,   48,  24}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    reg_addr = a;
    #2;
    d = reg_rdata;
  endtask

  task automatic count_hi(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int hi, hi2, v;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 oe after reset", 32'(pwm_oe), 32'h0);
    rd(12'h080, d); chk("R1 enable reg", d, 32'h0);
    rd(12'h104, d); chk("R1 period reg", d, 32'h0);
    rd(12'h020, d); chk("R1 pair reg", d, 32'h0);

    // R2 readback masks
    wr(12'h020, 32'hFFFF_FFFF); rd(12'h020, d); chk("R2 pair fields", d, 32'h18F);
    wr(12'h2E0, 32'hFFFF_FFFF); rd(12'h2E0, d); chk("R2 ctl fields", d, 32'h1FF);
    wr(12'h2E4, 32'h1234_5678); rd(12'h2E4, d); chk("R2 period fields", d, 32'h1234_5678);
    wr(12'h040, 32'hFFFF_FFFF); rd(12'h040, d); chk("R2 gate and bypass", d, 32'hFFFF_FFFF);
    wr(12'h040, 32'h0); wr(12'h020, 32'h0);

    // R3 unmapped addresses
    wr(12'h108, 32'hFFFF_FFFF);
    rd(12'h108, d); chk("R3 gap reads zero", d, 32'h0);
    rd(12'h104, d); chk("R3 neighbour period untouched", d, 32'h0);
    rd(12'h100, d); chk("R3 neighbour ctl untouched", d, 32'h0);
    rd(12'h044, d); chk("R3 unmapped reads zero", d, 32'h0);

    // table: channel 3 on pair 1 (R5 R6 R7 R8)
    for (int r = 0; r < 9; r++) begin
      wr(12'h080, 32'h0);
      wr(12'h024, 32'((ROWS[r].src << 7) | ROWS[r].dv));
      wr(12'h040, 32'h8);
      wr(12'h160, 32'((ROWS[r].pol << 8) | ROWS[r].pre));
      wr(12'h164, 32'((ROWS[r].ent << 16) | ROWS[r].act));
      wr(12'h080, 32'h8);
      repeat (ROWS[r].win) @(posedge clk);
      count_hi(3, ROWS[r].win, hi);
      chk($sformatf("R5 R6 R7 R8 row %0d high count", r), 32'(hi), 32'(ROWS[r].exp));
    end

    // R4 disable drops output enable
    @(negedge clk);
    chk("R4 oe while enabled", 32'(pwm_oe), 32'h8);
    wr(12'h080, 32'h0);
    @(negedge clk);
    chk("R4 oe while disabled", 32'(pwm_oe), 32'h0);

    // R10 immediate period change
    wr(12'h024, 32'h0);
    wr(12'h160, 32'h100);
    wr(12'h164, {16'd999, 16'd1000});
    wr(12'h080, 32'h8);
    repeat (100) @(posedge clk);
    count_hi(3, 20, hi);
    chk("R8 A above E stays active", 32'(hi), 32'd20);
    wr(12'h164, {16'd9, 16'd3});
    repeat (12) @(posedge clk);
    count_hi(3, 20, hi);
    chk("R10 new period acts at once", 32'(hi), 32'd6);

    // R11 gate clear freezes output
    wr(12'h040, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    v = pwm_out[3] ? 20 : 0;
    count_hi(3, 20, hi);
    chk("R11 gated output frozen", 32'(hi), 32'(v));

    // R12 bypass follows source strobe
    wr(12'h040, 32'h0008_0008);
    repeat (3) @(posedge clk);
    count_hi(3, 30, hi);
    chk("R12 bypass on oscillator", 32'(hi), 32'd30);
    wr(12'h024, 32'h80);
    repeat (3) @(posedge clk);
    count_hi(3, 30, hi);
    chk("R12 bypass on bus strobe", 32'(hi), 32'd10);

    // R9 pairs independent: ch2 on pair1 div 1, ch4 on pair2 div 0
    wr(12'h080, 32'h0);
    wr(12'h040, 32'h14);
    wr(12'h024, 32'h1);
    wr(12'h028, 32'h0);
    wr(12'h140, 32'h100); wr(12'h144, {16'd4, 16'd2});
    wr(12'h180, 32'h100); wr(12'h184, {16'd4, 16'd1});
    wr(12'h080, 32'h14);
    repeat (20) @(posedge clk);
    hi = 0; hi2 = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_out[2]) hi++;
      if (pwm_out[4]) hi2++;
    end
    chk("R9 channel 2 uses pair 1 divider", 32'(hi), 32'd8);
    chk("R9 channel 4 uses pair 2 divider", 32'(hi2), 32'd4);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule